// File: doc/BRIEF.md
# Processor clock and synchronization generator

This block turns one fast frequency source into the two clocks a small microprocessor system needs. It also hands the processor a reset level and a READY level, both re-timed to that clock. Two sources are offered: a crystal-oscillator square wave and an external frequency input. A select input picks one of them, and that source is divided by three to give the processor clock. The processor clock is divided by a further two to give a slower peripheral clock. The crystal wave is also passed straight out as an oscillator copy, so that another generator can use it as its external source.

The source waves are modelled as sampled levels. Every register runs on one fast modelled clock, and a rising edge of the selected source is detected on that clock. A clock-sync input holds the divider in its start state, which lets several generators line up on a common phase. The reset request is active low. Its inverse reaches the processor, updated only when the processor clock falls. The READY request is formed from two ready inputs, each gated by its own active-low enable, and passes through either one or two synchronizer stages as a mode input selects.

Top module: `clk_sync_gen`

## Requirements
- R1: With src_sel_i high, rising edges of ext_freq_i advance the divider. With src_sel_i low, rising edges of xtal_i advance it.
- R2: cpu_clk_o has a period of three selected-source periods. It is high for one source period and low for two.
- R3: per_clk_o toggles only on rising edges of cpu_clk_o. Its period is two cpu_clk_o periods, with equal high and low times.
- R4: osc_o always equals xtal_i, whatever the value of src_sel_i.
- R5: While csync_i is high, cpu_clk_o stays high and per_clk_o holds its value. After csync_i falls, the first rising edge of the selected source drives cpu_clk_o low, and that low phase lasts two source periods.
- R6: reset_o takes the inverse of rst_req_ni, and it changes only at the edge where cpu_clk_o falls.
- R7: The READY request is (rdy_a_i AND NOT aen_a_ni) OR (rdy_b_i AND NOT aen_b_ni). A ready input whose enable is high has no effect on ready_o.
- R8: With rdy_mode_i = 0 (two stages), a first stage captures the request where cpu_clk_o rises, and ready_o takes the first stage's value where cpu_clk_o next falls. A request applied just after a rising edge of cpu_clk_o reaches ready_o at the second falling edge.
- R9: With rdy_mode_i = 1 (one stage), ready_o captures the request where cpu_clk_o falls. A request applied just after a rising edge of cpu_clk_o reaches ready_o at the first falling edge.
- R10: While rst_ni is low, cpu_clk_o is 1, per_clk_o is 0, reset_o is 1 and ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast modelled clock that samples both sources |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xtal_i | input | 1 | Crystal-oscillator square wave |
| ext_freq_i | input | 1 | External frequency source |
| src_sel_i | input | 1 | 1 selects ext_freq_i, 0 selects xtal_i |
| csync_i | input | 1 | Holds the divider in its start state while high |
| rst_req_ni | input | 1 | Active-low reset request |
| rdy_a_i | input | 1 | First ready request |
| aen_a_ni | input | 1 | Active-low enable for rdy_a_i |
| rdy_b_i | input | 1 | Second ready request |
| aen_b_ni | input | 1 | Active-low enable for rdy_b_i |
| rdy_mode_i | input | 1 | 0 selects two READY stages, 1 selects one stage |
| osc_o | output | 1 | Copy of xtal_i |
| cpu_clk_o | output | 1 | Processor clock, source divided by three |
| per_clk_o | output | 1 | Peripheral clock, cpu_clk_o divided by two |
| reset_o | output | 1 | Active-high reset, re-timed to the falling edge of cpu_clk_o |
| ready_o | output | 1 | Synchronized READY output |

## Verification
The bench measures high and low phase lengths for each source and half-period pairing. A divider that counted the wrong source, or used the wrong duty split, would give phase counts that differ from the table. After csync_i is released, it times both the first falling edge and the low phase that follows, which exposes a divider that resumed from a state other than its start state. READY latency is counted in falling edges of cpu_clk_o from a request applied just after a rising edge: a swapped mode decode, or a stage clocked on the wrong edge, shifts that count by one. Every change of reset_o must line up with a falling edge of cpu_clk_o.

// File: rtl/csg_pkg.sv
package csg_pkg;
  typedef enum logic {
    RDY_TWO_STAGE = 1'b0,
    RDY_ONE_STAGE = 1'b1
  } rdy_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } clk_evt_t;
endpackage

// File: rtl/csg_src_div.sv
module csg_src_div
  import csg_pkg::*;
#(
  parameter int unsigned DIV = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     xtal_i,
  input  logic     ext_i,
  input  logic     src_sel_i,
  input  logic     csync_i,
  output logic     cpu_clk_o,
  output logic     per_clk_o,
  output clk_evt_t evt_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic             src, src_q, src_rise, adv;
  logic [CNT_W-1:0] cnt_q;
  logic             per_q;

  assign src      = src_sel_i ? ext_i : xtal_i;
  assign src_rise = src & ~src_q;
  assign adv      = src_rise & ~csync_i;

  assign evt_o.rise = adv & (cnt_q == LAST);
  assign evt_o.fall = adv & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      cnt_q <= '0;
      per_q <= 1'b0;
    end else begin
      src_q <= src;
      if (csync_i)                cnt_q <= '0;
      else if (src_rise)          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
      if (evt_o.rise)             per_q <= ~per_q;
    end
  end

  // high for one source period out of DIV
  assign cpu_clk_o = (cnt_q == '0);
  assign per_clk_o = per_q;

  // R5
  csync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csync_i |=> (cpu_clk_o && $stable(per_clk_o)));

  // R3
  pclk_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_clk_o) |-> $rose(cpu_clk_o));
endmodule

// File: rtl/csg_reset_sync.sv
module csg_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic req_ni,
  output logic reset_o
);
  logic reset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     reset_q <= 1'b1;
    else if (fall_i) reset_q <= ~req_ni;
  end

  assign reset_o = reset_q;

  // R6
  reset_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(reset_o) |-> ($past(fall_i) && (reset_o == !$past(req_ni))));
endmodule

// File: rtl/csg_ready_sync.sv
module csg_ready_sync
  import csg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_evt_t evt_i,
  input  logic     mode_i,
  input  logic     rdy_a_i,
  input  logic     aen_a_ni,
  input  logic     rdy_b_i,
  input  logic     aen_b_ni,
  output logic     ready_o
);
  rdy_mode_e mode;
  logic      req, stage1_q, ready_q;

  assign mode = rdy_mode_e'(mode_i);
  assign req  = (rdy_a_i & ~aen_a_ni) | (rdy_b_i & ~aen_b_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      if (evt_i.rise) stage1_q <= req;
      if (evt_i.fall) ready_q  <= (mode == RDY_ONE_STAGE) ? req : stage1_q;
    end
  end

  assign ready_o = ready_q;

  // R8
  ready_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ready_o) |-> $past(evt_i.fall));

  // R9
  one_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.fall && mode == RDY_ONE_STAGE) |=> (ready_o == $past(req)));
endmodule

// File: rtl/clk_sync_gen.sv
module clk_sync_gen
  import csg_pkg::*;
#(
  parameter int unsigned CLK_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xtal_i,
  input  logic ext_freq_i,
  input  logic src_sel_i,
  input  logic csync_i,
  input  logic rst_req_ni,
  input  logic rdy_a_i,
  input  logic aen_a_ni,
  input  logic rdy_b_i,
  input  logic aen_b_ni,
  input  logic rdy_mode_i,
  output logic osc_o,
  output logic cpu_clk_o,
  output logic per_clk_o,
  output logic reset_o,
  output logic ready_o
);
  clk_evt_t evt;

  assign osc_o = xtal_i;

  csg_src_div #(.DIV(CLK_DIV)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xtal_i    (xtal_i),
    .ext_i     (ext_freq_i),
    .src_sel_i (src_sel_i),
    .csync_i   (csync_i),
    .cpu_clk_o (cpu_clk_o),
    .per_clk_o (per_clk_o),
    .evt_o     (evt)
  );

  csg_reset_sync u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (evt.fall),
    .req_ni  (rst_req_ni),
    .reset_o (reset_o)
  );

  csg_ready_sync u_rdy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .mode_i   (rdy_mode_i),
    .rdy_a_i  (rdy_a_i),
    .aen_a_ni (aen_a_ni),
    .rdy_b_i  (rdy_b_i),
    .aen_b_ni (aen_b_ni),
    .ready_o  (ready_o)
  );

  // R6
  reset_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(reset_o) |-> $fell(cpu_clk_o));

  // R8
  ready_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ready_o) |-> $fell(cpu_clk_o));
endmodule

// File: tb/clk_sync_gen_test.sv
module clk_sync_gen_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic xtal = 1'b0, ext = 1'b0;
  logic src_sel = 1'b0, csync = 1'b0, rst_req_n = 1'b1;
  logic rdy_a = 1'b0, aen_a_n = 1'b1, rdy_b = 1'b0, aen_b_n = 1'b1, rdy_mode = 1'b0;
  logic osc, cpu_clk, per_clk, reset_s, ready_s;
  int   xtal_hp = 1, ext_hp = 3, xc = 0, ec = 0;
  int   checks = 0, failures = 0;

  always #2 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (xc + 1 >= xtal_hp) begin xtal <= ~xtal; xc <= 0; end else xc <= xc + 1;
    if (ec + 1 >= ext_hp)  begin ext  <= ~ext;  ec <= 0; end else ec <= ec + 1;
  end

  clk_sync_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .xtal_i(xtal), .ext_freq_i(ext),
    .src_sel_i(src_sel), .csync_i(csync), .rst_req_ni(rst_req_n),
    .rdy_a_i(rdy_a), .aen_a_ni(aen_a_n), .rdy_b_i(rdy_b), .aen_b_ni(aen_b_n),
    .rdy_mode_i(rdy_mode), .osc_o(osc), .cpu_clk_o(cpu_clk), .per_clk_o(per_clk),
    .reset_o(reset_s), .ready_o(ready_s)
  );

  typedef struct packed {
    logic sel;
    int   xhp;
    int   ehp;
    int   hi;
    int   lo;
  } vec_t;
  localparam int NV = 4;
  localparam vec_t VEC[NV] = '{
    '{1'b0, 1, 3, 2, 4},
    '{1'b1, 1, 3, 6, 12},
    '{1'b0, 2, 1, 4, 8},
    '{1'b1, 2, 1, 2, 4}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input logic pclk, output int hi, output int lo);
    do @(negedge clk_i); while ((pclk ? per_clk : cpu_clk) !== 1'b0);
    do @(negedge clk_i); while ((pclk ? per_clk : cpu_clk) !== 1'b1);
    hi = 0;
    while ((pclk ? per_clk : cpu_clk) === 1'b1) begin hi++; @(negedge clk_i); end
    lo = 0;
    while ((pclk ? per_clk : cpu_clk) === 1'b0) begin lo++; @(negedge clk_i); end
  endtask

  task automatic wait_clk_rise();
    logic p;
    p = cpu_clk;
    forever begin
      @(negedge clk_i);
      if (!p && cpu_clk) break;
      p = cpu_clk;
    end
  endtask

  task automatic falls_to_ready(output int n);
    logic p;
    n = 0;
    p = cpu_clk;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (p && !cpu_clk) n++;
      if (ready_s) break;
      p = cpu_clk;
    end
  endtask

  task automatic watch_reset(input int n);
    logic pc, pr;
    pc = cpu_clk;
    pr = reset_s;
    repeat (n) begin
      @(negedge clk_i);
      if (reset_s !== pr) chk(pc === 1'b1 && cpu_clk === 1'b0, "R6 change off CLK fall", int'(cpu_clk), 0);
      pc = cpu_clk;
      pr = reset_s;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hi, lo, n;
    logic held_p;
    // R10 reset state
    repeat (5) @(negedge clk_i);
    chk(cpu_clk === 1'b1, "R10 cpu_clk", int'(cpu_clk), 1);
    chk(per_clk === 1'b0, "R10 per_clk", int'(per_clk), 0);
    chk(reset_s === 1'b1, "R10 reset_o", int'(reset_s), 1);
    chk(ready_s === 1'b0, "R10 ready_o", int'(ready_s), 0);
    rst_ni = 1'b1;

    // R1 R2 R3 vector walk
    for (int v = 0; v < NV; v++) begin
      src_sel = VEC[v].sel;
      xtal_hp = VEC[v].xhp;
      ext_hp  = VEC[v].ehp;
      repeat (60) @(negedge clk_i);
      measure(1'b0, hi, lo);
      chk(hi == VEC[v].hi, "R1/R2 clk high", hi, VEC[v].hi);
      chk(lo == VEC[v].lo, "R1/R2 clk low", lo, VEC[v].lo);
      measure(1'b1, hi, lo);
      chk(hi == VEC[v].hi + VEC[v].lo, "R3 pclk high", hi, VEC[v].hi + VEC[v].lo);
      chk(lo == VEC[v].hi + VEC[v].lo, "R3 pclk low", lo, VEC[v].hi + VEC[v].lo);
    end

    // R4 osc copy with external source selected
    src_sel = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk_i); #1;
      chk(osc === xtal, "R4 osc", int'(osc), int'(xtal));
    end

    // R5 clock sync hold and restart
    src_sel = 1'b0; xtal_hp = 1;
    repeat (30) @(negedge clk_i);
    csync = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    held_p = per_clk;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      chk(cpu_clk === 1'b1, "R5 clk held high", int'(cpu_clk), 1);
    end
    chk(per_clk === held_p, "R5 pclk held", int'(per_clk), int'(held_p));
    csync = 1'b0;
    n = 0;
    do begin @(negedge clk_i); n++; end while (cpu_clk === 1'b1 && n < 50);
    chk(n <= 2, "R5 first fall", n, 2);
    lo = 0;
    while (cpu_clk === 1'b0) begin lo++; @(negedge clk_i); end
    chk(lo == 4, "R5 low after restart", lo, 4);

    // R6 reset re-timing
    chk(reset_s === 1'b0, "R6 reset released", int'(reset_s), 0);
    rst_req_n = 1'b0;
    watch_reset(40);
    chk(reset_s === 1'b1, "R6 reset asserted", int'(reset_s), 1);
    rst_req_n = 1'b1;
    watch_reset(40);
    chk(reset_s === 1'b0, "R6 reset deasserted", int'(reset_s), 0);

    // R8 two-stage latency
    rdy_mode = 1'b0;
    wait_clk_rise();
    rdy_a = 1'b1; aen_a_n = 1'b0;
    falls_to_ready(n);
    chk(n == 2, "R8 two-stage falls", n, 2);
    rdy_a = 1'b0;
    repeat (40) @(negedge clk_i);
    chk(ready_s === 1'b0, "R8 ready drops", int'(ready_s), 0);

    // R9 one-stage latency
    rdy_mode = 1'b1;
    wait_clk_rise();
    rdy_b = 1'b1; aen_b_n = 1'b0;
    falls_to_ready(n);
    chk(n == 1, "R9 one-stage falls", n, 1);
    rdy_b = 1'b0;
    repeat (40) @(negedge clk_i);

    // R7 enable gating
    rdy_a = 1'b1; aen_a_n = 1'b1; rdy_b = 1'b0; aen_b_n = 1'b0;
    repeat (40) @(negedge clk_i);
    chk(ready_s === 1'b0, "R7 a disabled", int'(ready_s), 0);
    rdy_b = 1'b1;
    repeat (40) @(negedge clk_i);
    chk(ready_s === 1'b1, "R7 b enabled", int'(ready_s), 1);
    aen_b_n = 1'b1;
    repeat (40) @(negedge clk_i);
    chk(ready_s === 1'b0, "R7 both disabled", int'(ready_s), 0);
    aen_a_n = 1'b0;
    repeat (40) @(negedge clk_i);
    chk(ready_s === 1'b1, "R7 a enabled", int'(ready_s), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule